// File: doc/BRIEF.md
# Transceiver Power State Sequencer

This block sequences the power states of a serial transceiver tile with several channels. Each channel has a transmit and a receive direction, and each direction has its own power-state request. The block counts every change between states on a slow management tick. The tick comes from dividing the input clock by a runtime setting, to about 25 MHz. Three per-channel tick counts set the duration of a change: one for entering the deepest state P2, one for leaving P2, and one for any other change. When a change completes, the direction pulses a done strobe and its status output shows the new state.

A shared PLL power-down input and an active-low reference-clock enable act on every channel and direction at once. While either holds the tile off, no direction reports ready and state requests are ignored. After release, each channel waits out its ordinary transition count before it reports ready again. Each channel also has a PCI Express mode. In that mode, a fixed pattern on its electrical-idle and disparity sideband inputs forces both directions of the channel toward P2.

Top module: `xps_pwr_seq`

## Requirements
- R1: The management tick fires once every `div_i` clock cycles, and a value of 0 behaves as 1. A change lasting N ticks completes between 3N-2 and 3N cycles after it is latched when `div_i`=3, and exactly N cycles after it is latched when `div_i` is 0 or 1.
- R2: States are coded P0=00, P0s=01, P1=10, P2=11. A request that differs from the current state is latched only when the direction is idle and ready. A request that changes while a transition is running is ignored until that transition completes, and is then taken up.
- R3: A change whose target is P2 lasts `to_p2_ticks_i` ticks of its channel.
- R4: A change whose source is P2 and whose target is not P2 lasts `from_p2_ticks_i` ticks of its channel.
- R5: Any other change lasts `other_ticks_i` ticks of its channel, and a count of 0 behaves as 1.
- R6: The done strobe is high for exactly one cycle, in the same cycle that the state output first shows the new state. The state output never changes without a done strobe.
- R7: While `pll_pd_i`=1 or `refclk_pd_ni`=0, every ready output is low and every state output holds. Requests are ignored, and a transition in progress is abandoned without a done strobe.
- R8: After the shared power-down is released, a channel's ready outputs return after `other_ticks_i` ticks (0 behaves as 1), with no done strobe. Requests still pending are then carried out.
- R9: When `pcie_en_i`=1 for a channel, the input pattern elec_idle=1, disp_mode=1, disp_val=0 replaces both of that channel's requests with P2. When the pattern is removed, or when `pcie_en_i`=0, the plain requests apply.
- R10: Each direction of each channel sequences independently and concurrently.
- R11: Reset (`rst_ni` low, asynchronous) sets every state to P0, clears every counter and the done strobes, and leaves every direction ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Tick divider, 0 treated as 1 |
| pll_pd_i | input | 1 | Shared PLL power-down |
| refclk_pd_ni | input | 1 | Shared reference clock enable, low powers down |
| tx_pd_i | input | NCH x 2 | Transmit power-state request per channel |
| rx_pd_i | input | NCH x 2 | Receive power-state request per channel |
| pcie_en_i | input | NCH | PCI Express sideband decode enable per channel |
| tx_elec_idle_i | input | NCH | Electrical-idle sideband per channel |
| tx_disp_mode_i | input | NCH | Disparity-mode sideband per channel |
| tx_disp_val_i | input | NCH | Disparity-value sideband per channel |
| to_p2_ticks_i | input | NCH x CNT_W | Ticks to enter P2 |
| from_p2_ticks_i | input | NCH x CNT_W | Ticks to leave P2 |
| other_ticks_i | input | NCH x CNT_W | Ticks for other changes and for power-up recovery |
| tx_state_o | output | NCH x 2 | Current transmit state |
| rx_state_o | output | NCH x 2 | Current receive state |
| tx_done_o | output | NCH | Transmit change complete strobe |
| rx_done_o | output | NCH | Receive change complete strobe |
| tx_ready_o | output | NCH | Transmit direction accepts requests |
| rx_ready_o | output | NCH | Receive direction accepts requests |

## Verification
The bench builds the block with two channels, a 4-bit divider and 8-bit counts. Channel 0 uses the tick counts 5, 7 and 3, and channel 1 uses 4, 6 and 0. With distinct counts, each transition kind yields its own completion cycle, so a wrong duration selection is visible. The zero count on channel 1 reaches the clamp-to-one path in both transitions and recovery. Running mostly at a divider of 1 makes every latency exact. Divider settings of 3 and 0 then cover the clamp and the phase-dependent window.

// File: rtl/xps_pkg.sv
package xps_pkg;
  typedef enum logic [1:0] {
    PS_P0  = 2'b00,
    PS_P0S = 2'b01,
    PS_P1  = 2'b10,
    PS_P2  = 2'b11
  } pstate_e;

  localparam int unsigned DIRS = 2;  // tx, rx
endpackage

// File: rtl/xps_tick_gen.sv
module xps_tick_gen #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // zero divider behaves as one: tick every cycle
  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/xps_req_decode.sv
module xps_req_decode (
  input  logic       pcie_en_i,
  input  logic       elec_idle_i,
  input  logic       disp_mode_i,
  input  logic       disp_val_i,
  input  logic [1:0] tx_req_i,
  input  logic [1:0] rx_req_i,
  output logic [1:0] tx_req_o,
  output logic [1:0] rx_req_o
);
  import xps_pkg::*;

  logic pd_hit;

  assign pd_hit   = pcie_en_i & elec_idle_i & disp_mode_i & ~disp_val_i;
  assign tx_req_o = pd_hit ? PS_P2 : tx_req_i;
  assign rx_req_o = pd_hit ? PS_P2 : rx_req_i;
endmodule

// File: rtl/xps_dir_seq.sv
module xps_dir_seq #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             off_i,
  input  logic [1:0]       req_i,
  input  logic [CNT_W-1:0] to_p2_i,
  input  logic [CNT_W-1:0] from_p2_i,
  input  logic [CNT_W-1:0] other_i,
  output logic [1:0]       state_o,
  output logic             done_o,
  output logic             ready_o
);
  import xps_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pstate_e          cur_q, tgt_q, req;
  logic             busy_q, rec_q, done_q;
  logic [CNT_W-1:0] cnt_q, dur;
  logic             last;

  assign req     = pstate_e'(req_i);
  assign ready_o = ~off_i & ~rec_q;
  assign state_o = cur_q;
  assign done_o  = done_q;
  assign last    = (cnt_q <= ONE);  // 0 and 1 both finish on this tick

  always_comb begin
    if (req == PS_P2)        dur = to_p2_i;
    else if (cur_q == PS_P2) dur = from_p2_i;
    else                     dur = other_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= PS_P0;
      tgt_q  <= PS_P0;
      busy_q <= 1'b0;
      rec_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (off_i) begin
        // abandon any change, arm recovery
        busy_q <= 1'b0;
        rec_q  <= 1'b1;
        cnt_q  <= other_i;
      end else if (rec_q) begin
        if (tick_i) begin
          if (last) begin
            rec_q <= 1'b0;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end else if (busy_q) begin
        if (tick_i) begin
          if (last) begin
            cur_q  <= tgt_q;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end else if (req != cur_q) begin
        busy_q <= 1'b1;
        tgt_q  <= req;
        cnt_q  <= dur;
      end
    end
  end
endmodule

// File: rtl/xps_pwr_seq.sv
module xps_pwr_seq #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned DIV_W = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DIV_W-1:0]          div_i,
  input  logic                      pll_pd_i,
  input  logic                      refclk_pd_ni,
  input  logic [NCH-1:0][1:0]       tx_pd_i,
  input  logic [NCH-1:0][1:0]       rx_pd_i,
  input  logic [NCH-1:0]            pcie_en_i,
  input  logic [NCH-1:0]            tx_elec_idle_i,
  input  logic [NCH-1:0]            tx_disp_mode_i,
  input  logic [NCH-1:0]            tx_disp_val_i,
  input  logic [NCH-1:0][CNT_W-1:0] to_p2_ticks_i,
  input  logic [NCH-1:0][CNT_W-1:0] from_p2_ticks_i,
  input  logic [NCH-1:0][CNT_W-1:0] other_ticks_i,
  output logic [NCH-1:0][1:0]       tx_state_o,
  output logic [NCH-1:0][1:0]       rx_state_o,
  output logic [NCH-1:0]            tx_done_o,
  output logic [NCH-1:0]            rx_done_o,
  output logic [NCH-1:0]            tx_ready_o,
  output logic [NCH-1:0]            rx_ready_o
);
  import xps_pkg::*;

  localparam int unsigned NU = NCH * DIRS;  // unit k = ch*2 + dir, dir 0 = tx

  logic                tick;
  logic                off;
  logic [NU-1:0][1:0]  u_req;
  logic [NU-1:0][1:0]  u_state;
  logic [NU-1:0]       u_done;
  logic [NU-1:0]       u_ready;

  assign off = pll_pd_i | ~refclk_pd_ni;

  xps_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .tick_o (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    xps_req_decode u_dec (
      .pcie_en_i   (pcie_en_i[c]),
      .elec_idle_i (tx_elec_idle_i[c]),
      .disp_mode_i (tx_disp_mode_i[c]),
      .disp_val_i  (tx_disp_val_i[c]),
      .tx_req_i    (tx_pd_i[c]),
      .rx_req_i    (rx_pd_i[c]),
      .tx_req_o    (u_req[c*DIRS]),
      .rx_req_o    (u_req[c*DIRS+1])
    );

    for (genvar d = 0; d < DIRS; d++) begin : g_dir
      xps_dir_seq #(.CNT_W(CNT_W)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .off_i     (off),
        .req_i     (u_req[c*DIRS+d]),
        .to_p2_i   (to_p2_ticks_i[c]),
        .from_p2_i (from_p2_ticks_i[c]),
        .other_i   (other_ticks_i[c]),
        .state_o   (u_state[c*DIRS+d]),
        .done_o    (u_done[c*DIRS+d]),
        .ready_o   (u_ready[c*DIRS+d])
      );
    end

    assign tx_state_o[c] = u_state[c*DIRS];
    assign rx_state_o[c] = u_state[c*DIRS+1];
    assign tx_done_o[c]  = u_done[c*DIRS];
    assign rx_done_o[c]  = u_done[c*DIRS+1];
    assign tx_ready_o[c] = u_ready[c*DIRS];
    assign rx_ready_o[c] = u_ready[c*DIRS+1];
  end
endmodule

// File: rtl/xps_pwr_seq_chk.sv
module xps_pwr_seq_chk #(
  parameter int unsigned NU = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pll_pd_i,
  input logic               refclk_pd_ni,
  input logic [NU-1:0][1:0] u_state,
  input logic [NU-1:0]      u_done,
  input logic [NU-1:0]      u_ready
);
  logic off;
  assign off = pll_pd_i | ~refclk_pd_ni;

  for (genvar k = 0; k < NU; k++) begin : g_u
    a_r6_done_moves_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
      u_done[k] |-> u_state[k] != $past(u_state[k]));

    a_r6_move_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      u_state[k] != $past(u_state[k]) |-> u_done[k]);

    a_r7_off_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off |-> !u_ready[k]);

    a_r7_off_holds_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off |=> $stable(u_state[k]));

    a_r7_done_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      u_done[k] |-> $past(u_ready[k]));
  end
endmodule

bind xps_pwr_seq xps_pwr_seq_chk #(.NU(NU)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pll_pd_i     (pll_pd_i),
  .refclk_pd_ni (refclk_pd_ni),
  .u_state      (u_state),
  .u_done       (u_done),
  .u_ready      (u_ready)
);

// File: tb/tb_xps_pwr_seq.sv
module tb_xps_pwr_seq;
  localparam int NCH = 2, DIV_W = 4, CNT_W = 8;
  localparam logic [1:0] P0 = 2'b00, P0S = 2'b01, P1 = 2'b10, P2 = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] div;
  logic pll_pd, refclk_pd_n;
  logic [NCH-1:0][1:0] tx_pd, rx_pd, tx_state, rx_state;
  logic [NCH-1:0] pcie_en, eidle, dmode, dval, tx_done, rx_done, tx_rdy, rx_rdy;
  logic [NCH-1:0][CNT_W-1:0] to_p2, from_p2, other;

  always #10 clk = ~clk;

  xps_pwr_seq #(.NCH(NCH), .DIV_W(DIV_W), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .pll_pd_i(pll_pd), .refclk_pd_ni(refclk_pd_n),
    .tx_pd_i(tx_pd), .rx_pd_i(rx_pd), .pcie_en_i(pcie_en), .tx_elec_idle_i(eidle),
    .tx_disp_mode_i(dmode), .tx_disp_val_i(dval), .to_p2_ticks_i(to_p2),
    .from_p2_ticks_i(from_p2), .other_ticks_i(other), .tx_state_o(tx_state),
    .rx_state_o(rx_state), .tx_done_o(tx_done), .rx_done_o(rx_done),
    .tx_ready_o(tx_rdy), .rx_ready_o(rx_rdy)
  );

  typedef struct { int unit; logic [1:0] st; int lo; int hi; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] state_of(int k);
    return (k % 2 == 1) ? rx_state[k/2] : tx_state[k/2];
  endfunction

  wire [3:0] done4 = {rx_done[1], tx_done[1], rx_done[0], tx_done[0]};
  wire [3:0] rdy4  = {rx_rdy[1], tx_rdy[1], rx_rdy[0], tx_rdy[0]};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_req(input int k, input logic [1:0] s);
    if (k % 2 == 1) rx_pd[k/2] = s; else tx_pd[k/2] = s;
  endtask

  // driver side: push expected completion window relative to current cycle
  task automatic expect_done(input int k, input logic [1:0] s, input int lo, input int hi,
                             input string tag);
    q.push_back('{unit: k, st: s, lo: cyc + lo, hi: cyc + hi, tag: tag});
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: every done strobe must match the head of the queue (R6)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        if (done4[k]) begin
          if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R6 unexpected done unit=%0d actual=1 expected=0", k);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.unit == k, {e.tag, " R6 unit"}, k, e.unit);
            chk(state_of(k) == e.st, {e.tag, " R6 state"}, state_of(k), e.st);
            chk(cyc >= e.lo && cyc <= e.hi, {e.tag, " done cycle"}, cyc, e.lo);
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int c;
    div = 4'd1; pll_pd = 1'b0; refclk_pd_n = 1'b1;
    tx_pd = '0; rx_pd = '0; pcie_en = '0; eidle = '0; dmode = '0; dval = '0;
    to_p2[0] = 8'd5; from_p2[0] = 8'd7; other[0] = 8'd3;
    to_p2[1] = 8'd4; from_p2[1] = 8'd6; other[1] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    for (int k = 0; k < 4; k++) chk(state_of(k) == P0, "R11 state", state_of(k), P0);
    chk(done4 == 4'b0, "R11 done", done4, 0);
    chk(rdy4 == 4'hF, "R11 ready", rdy4, 15);

    @(negedge clk); set_req(0, P1);  expect_done(0, P1, 4, 4, "R5"); drain();
    @(negedge clk); set_req(0, P2);  expect_done(0, P2, 6, 6, "R3"); drain();
    @(negedge clk); set_req(0, P0S); expect_done(0, P0S, 8, 8, "R4"); drain();
    @(negedge clk); set_req(3, P0S); expect_done(3, P0S, 2, 2, "R5 zero count"); drain();

    // R10 concurrent directions with different durations
    @(negedge clk);
    set_req(0, P0); expect_done(0, P0, 4, 4, "R10 tx0");
    set_req(1, P2); expect_done(1, P2, 6, 6, "R10 rx0");
    drain();

    // R2 request change while busy is held off, then taken up
    @(negedge clk);
    set_req(1, P1);
    expect_done(1, P1, 8, 8, "R2 first");
    expect_done(1, P0S, 12, 12, "R2 deferred");
    repeat (2) @(negedge clk);
    set_req(1, P0S);
    drain();

    // R7 / R8 shared PLL power-down
    @(negedge clk); set_req(0, P2);
    repeat (2) @(negedge clk);
    pll_pd = 1'b1;
    #1 chk(rdy4 == 4'h0, "R7 ready low", rdy4, 0);
    set_req(3, P1);
    repeat (8) @(negedge clk);
    chk(tx_state[0] == P0, "R7 tx0 held", tx_state[0], P0);
    chk(rx_state[1] == P0S, "R7 rx1 held", rx_state[1], P0S);
    @(negedge clk);
    pll_pd = 1'b0;
    c = cyc;
    expect_done(3, P1, 3, 3, "R8 rx1 resume");
    expect_done(0, P2, 9, 9, "R8 tx0 resume");
    #1 chk(rdy4 == 4'h0, "R8 still recovering", rdy4, 0);
    @(negedge clk);
    chk(tx_rdy[1] && rx_rdy[1], "R8 ch1 ready at 1 tick", int'(tx_rdy[1]), 1);
    chk(!tx_rdy[0], "R8 ch0 not yet", int'(tx_rdy[0]), 0);
    @(negedge clk);
    chk(!rx_rdy[0], "R8 ch0 not yet at 2", int'(rx_rdy[0]), 0);
    @(negedge clk);
    chk(tx_rdy[0] && rx_rdy[0] && cyc == c + 3, "R8 ch0 ready at 3 ticks", int'(tx_rdy[0]), 1);
    drain();

    // R7 reference clock enable low
    @(negedge clk); refclk_pd_n = 1'b0;
    #1 chk(rdy4 == 4'h0, "R7 refclk ready low", rdy4, 0);
    repeat (3) @(negedge clk);
    refclk_pd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(rdy4 == 4'hF, "R8 ready after refclk", rdy4, 15);

    // R9 sideband pattern, mode disabled then enabled
    eidle[1] = 1'b1; dmode[1] = 1'b1; dval[1] = 1'b0;
    repeat (10) @(negedge clk);
    chk(tx_state[1] == P0, "R9 disabled tx1", tx_state[1], P0);
    chk(rx_state[1] == P1, "R9 disabled rx1", rx_state[1], P1);
    pcie_en[1] = 1'b1;
    expect_done(2, P2, 5, 5, "R9 tx1 to P2");
    expect_done(3, P2, 5, 5, "R9 rx1 to P2");
    drain();
    @(negedge clk); eidle[1] = 1'b0;
    expect_done(2, P0, 7, 7, "R9 tx1 release");
    expect_done(3, P1, 7, 7, "R9 rx1 release");
    drain();

    // R1 divider
    @(negedge clk); div = 4'd3;
    set_req(1, P1); expect_done(1, P1, 8, 10, "R1 div3");
    drain();
    @(negedge clk); div = 4'd0;
    set_req(1, P0); expect_done(1, P0, 4, 4, "R1 div0");
    drain();

    chk(q.size() == 0, "R6 queue empty", q.size(), 0);
    finish_run();
  end
endmodule